// File: doc/BRIEF.md
# Bayer Defective Pixel Corrector

This block sits in a raw image pipeline and repairs stuck-bright (hot) and stuck-dark (cold) sensor pixels on the fly. Pixels arrive one per valid beat, in raster order. A frame-start flag marks the first pixel of a frame and a line-start flag marks the first pixel of each line. Four line buffers and a 5x5 shift window give the block each pixel together with the pixels around it. In colour mode the eight pixels at distance two share the centre's colour filter, and these eight are used. In monochrome mode the eight immediate neighbours are used.

A pixel is repaired when it lies above the brightest of its eight neighbours, or below the darkest, by more than a programmable threshold. The repaired value is either the median or the mean of the eight neighbours. At the frame edges, window taps that fall outside the frame are either mirrored across the centre or the edge pixel is passed through unrepaired. A bypass setting passes every pixel unchanged. The latency is the same in every mode, and the two sync flags travel with their pixel so that they stay aligned with the output.

Configuration is done through a small write-only register port. Register changes are meant to be made between frames, with the block held in reset.

Top module: `bayer_dpc`

## Requirements
- R1: With programmed line width W, the output beat registered at the (m+2W+3)-th input valid beat carries input pixel m. Its frame-start and line-start flags equal those that pixel m entered with. out_valid is high in the cycle after each input valid beat.
- R2: With bypass set (control bit 0 = 1), every output pixel equals its input pixel, and the latency is the same as in R1.
- R3: A pixel is treated as hot and replaced only when its value is strictly greater than the largest neighbour plus the threshold. A value exactly equal to that sum passes unchanged.
- R4: A pixel is treated as cold and replaced only when its value plus the threshold is strictly less than the smallest neighbour.
- R5: With control bit 2 = 0, the replacement is floor((a+b)/2), where a and b are the 4th and 5th smallest of the eight neighbours.
- R6: With control bit 2 = 1, the replacement is floor(sum of the eight neighbours / 8).
- R7: In colour mode (control bit 1 = 0), the neighbours are the pixels at row and column offsets in {-2,0,+2}, excluding the centre. Pixels at distance one have no effect on detection or replacement.
- R8: In monochrome mode (control bit 1 = 1), the neighbours are the eight pixels at offsets in {-1,0,+1}.
- R9: With control bit 3 = 0, a neighbour tap whose row lies outside 0..H-1 is taken from the mirrored row offset. The same applies to columns outside 0..W-1. Edge pixels are still corrected.
- R10: With control bit 3 = 1, a pixel whose neighbourhood reaches outside the frame is passed unchanged, even when it is an outlier.
- R11: Register writes (cfg_we high at a clock edge) are decoded by cfg_addr: 0 = control {bit3 skip-edge, bit2 mean, bit1 mono, bit0 bypass}, 1 = threshold, 2 = line width W, 3 = frame height H.
  - Reset values are control 0, threshold 0, W = MAX_W and H = MAX_H. After reset, out_valid and out_pix are 0.
  - Colour mode needs W and H of at least 5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select |
| cfg_wdata | input | CW | Register write data |
| in_valid | input | 1 | Input pixel beat |
| in_fs | input | 1 | First pixel of frame |
| in_ls | input | 1 | First pixel of line |
| in_pix | input | DW | Input pixel value |
| out_valid | output | 1 | Output pixel beat |
| out_fs | output | 1 | Delayed frame-start flag |
| out_ls | output | 1 | Delayed line-start flag |
| out_pix | output | DW | Corrected pixel value |

## Verification
Each result is due 2W+3 input beats after its pixel enters, counted in valid beats rather than in clocks. Idle cycles therefore do not move it, and an idle cycle at the end of every line exercises this.

For each input beat the driver queues the expected pixel and flags. After each reset it first queues 2W+3 placeholder entries for the window fill. The monitor pops one entry for every out_valid cycle, sampling at the falling edge. Since both sides advance only on beats, the comparison stays in step with the latency. A run of flush beats drains the last two lines, and the queue must be empty at the end.

// File: rtl/dpc_pkg.sv
// Shared types and constants for the defective pixel corrector.
// Assumes: all users import this package; register addresses are fixed.
package dpc_pkg;

    // Control register fields; bypass is bit 0, skip_edge bit 3.
    typedef struct packed {
        logic skip_edge;
        logic use_mean;
        logic mono;
        logic bypass;
    } dpc_ctrl_t;

    localparam logic [1:0] ADDR_CTRL   = 2'd0;
    localparam logic [1:0] ADDR_THR    = 2'd1;
    localparam logic [1:0] ADDR_WIDTH  = 2'd2;
    localparam logic [1:0] ADDR_HEIGHT = 2'd3;

    localparam int NUM_NB = 8;
    // Direction table for the eight neighbours (row step, column step).
    localparam int DIR_Y [NUM_NB] = '{-1, -1, -1, 0, 0, 1, 1, 1};
    localparam int DIR_X [NUM_NB] = '{-1, 0, 1, -1, 1, -1, 0, 1};

endpackage

// File: rtl/dpc_window.sv
// Line buffers and 5x5 window for the pixel corrector.
// Holds four previous lines in ring buffers wrapping at the programmed width
// and shifts five taps per row on every valid beat. Each entry carries the
// pixel with its frame-start and line-start flags so sync delay is implicit.
// Assumes: every line has exactly `width` beats, width <= MAX_W.
module dpc_window #(
    parameter int DW    = 8,
    parameter int MAX_W = 64,
    parameter int XW    = $clog2(MAX_W + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic                     in_fs,
    input  logic                     in_ls,
    input  logic [DW-1:0]            in_pix,
    input  logic [XW-1:0]            width,
    output logic [4:0][4:0][DW-1:0]  win,
    output logic                     ctr_fs,
    output logic                     ctr_ls,
    output logic                     nxt_fs,
    output logic                     nxt_ls
);
    localparam int EW   = DW + 2;
    localparam int AW   = (MAX_W > 1) ? $clog2(MAX_W) : 1;
    localparam int ROWS = 5;
    localparam int LBUF = ROWS - 1;

    typedef logic [EW-1:0] ent_t;

    ent_t          mem [LBUF][MAX_W];
    ent_t          sr  [ROWS][ROWS];
    ent_t          tap [ROWS];
    logic [AW-1:0] ptr;
    logic          ptr_last;

    // Column taps: row 0 is the live input, row r is r lines old.
    always_comb begin
        tap[0] = {in_fs, in_ls, in_pix};
        for (int r = 1; r < ROWS; r++) begin
            tap[r] = mem[r-1][ptr];
        end
    end

    // Wrap point of the ring pointer.
    assign ptr_last = ((XW'(ptr) + XW'(1)) >= width) || (ptr == AW'(MAX_W - 1));

    // Advance line buffers and window shift registers on each beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
            for (int r = 0; r < LBUF; r++) begin
                for (int i = 0; i < MAX_W; i++) begin
                    mem[r][i] <= '0;
                end
            end
            for (int r = 0; r < ROWS; r++) begin
                for (int i = 0; i < ROWS; i++) begin
                    sr[r][i] <= '0;
                end
            end
        end else if (en) begin
            ptr <= ptr_last ? '0 : ptr + AW'(1);
            for (int r = 0; r < LBUF; r++) begin
                mem[r][ptr] <= tap[r];
            end
            for (int r = 0; r < ROWS; r++) begin
                sr[r][0] <= tap[r];
                for (int i = 1; i < ROWS; i++) begin
                    sr[r][i] <= sr[r][i-1];
                end
            end
        end
    end

    // Present the window with row 0 at the top (oldest) and column 0 left.
    for (genvar y = 0; y < ROWS; y++) begin : g_wy
        for (genvar x = 0; x < ROWS; x++) begin : g_wx
            assign win[y][x] = sr[LBUF-y][LBUF-x][DW-1:0];
        end
    end

    assign ctr_fs = sr[2][2][DW+1];
    assign ctr_ls = sr[2][2][DW];
    assign nxt_fs = sr[2][1][DW+1];
    assign nxt_ls = sr[2][1][DW];

    // The ring pointer never leaves the programmed line (R1).
    p_ptr_wraps_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (en && ptr_last) |=> (ptr == '0));

endmodule

// File: rtl/dpc_estimate.sv
// Order statistics and mean of eight neighbour values.
// Ranks each value (ties broken by index), picks min, max and the two middle
// values, and sums all eight. Purely combinational; clock only for checks.
module dpc_estimate #(
    parameter int DW = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [7:0][DW-1:0]  nb,
    output logic [DW-1:0]       nmin,
    output logic [DW-1:0]       nmax,
    output logic [DW-1:0]       nmed,
    output logic [DW-1:0]       nmean
);
    localparam int N  = 8;
    localparam int SW = DW + $clog2(N);

    logic [2:0]    rank [N];
    logic [DW-1:0] mid_lo, mid_hi;
    logic [DW:0]   mid_sum;
    logic [SW-1:0] total;

    // Rank of each neighbour among the eight.
    for (genvar i = 0; i < N; i++) begin : g_rank
        always_comb begin
            int cnt;
            cnt = 0;
            for (int j = 0; j < N; j++) begin
                if ((nb[j] < nb[i]) || ((nb[j] == nb[i]) && (j < i))) begin
                    cnt = cnt + 1;
                end
            end
            rank[i] = 3'(cnt);
        end
    end

    // Select extremes and middle pair by rank.
    always_comb begin
        nmin   = '0;
        nmax   = '0;
        mid_lo = '0;
        mid_hi = '0;
        for (int i = 0; i < N; i++) begin
            if (rank[i] == 3'd0) nmin   = nb[i];
            if (rank[i] == 3'd7) nmax   = nb[i];
            if (rank[i] == 3'd3) mid_lo = nb[i];
            if (rank[i] == 3'd4) mid_hi = nb[i];
        end
    end

    // Median as floor of the middle pair's average.
    assign mid_sum = {1'b0, mid_lo} + {1'b0, mid_hi};
    assign nmed    = mid_sum[DW:1];

    // Mean as the sum divided by eight.
    always_comb begin
        total = '0;
        for (int i = 0; i < N; i++) begin
            total = total + SW'(nb[i]);
        end
    end
    assign nmean = total[SW-1:3];

    p_median_bounded_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (nmin <= nmed) && (nmed <= nmax));
    p_mean_bounded_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (nmin <= nmean) && (nmean <= nmax));

endmodule

// File: rtl/bayer_dpc.sv
// Defective pixel corrector for raw Bayer or monochrome streams.
// Holds the register set, tracks the centre pixel's frame position, picks
// eight neighbours (distance two in colour, one in monochrome) with mirrored
// edges, detects outliers against a threshold and registers the result.
// Assumes: lines of exactly W beats, frames of H lines, settings changed
// only between frames under reset.
module bayer_dpc
    import dpc_pkg::*;
#(
    parameter int DW    = 8,
    parameter int MAX_W = 64,
    parameter int MAX_H = 64,
    parameter int CW    = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_addr,
    input  logic [CW-1:0] cfg_wdata,
    input  logic          in_valid,
    input  logic          in_fs,
    input  logic          in_ls,
    input  logic [DW-1:0] in_pix,
    output logic          out_valid,
    output logic          out_fs,
    output logic          out_ls,
    output logic [DW-1:0] out_pix
);
    localparam int XW = $clog2(MAX_W + 1);
    localparam int YW = $clog2(MAX_H + 1);

    dpc_ctrl_t               ctrl;
    logic [DW-1:0]           thr;
    logic [XW-1:0]           width;
    logic [YW-1:0]           height;
    logic [4:0][4:0][DW-1:0] win;
    logic                    ctr_fs, ctr_ls, nxt_fs, nxt_ls;
    logic [YW-1:0]           crow;
    logic [XW-1:0]           ccol;
    logic [1:0]              kk;
    logic                    ok_up, ok_dn, ok_lf, ok_rt, border;
    logic [7:0][DW-1:0]      nb;
    logic [DW-1:0]           nmin, nmax, nmed, nmean, est, ctr_pix;
    logic                    hot, cold, fix;
    logic                    unused_cfg;

    assign unused_cfg = ^cfg_wdata;

    // Register writes and reset defaults.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl   <= '0;
            thr    <= '0;
            width  <= XW'(MAX_W);
            height <= YW'(MAX_H);
        end else if (cfg_we) begin
            case (cfg_addr)
                ADDR_CTRL:   ctrl   <= cfg_wdata[3:0];
                ADDR_THR:    thr    <= cfg_wdata[DW-1:0];
                ADDR_WIDTH:  width  <= cfg_wdata[XW-1:0];
                default:     height <= cfg_wdata[YW-1:0];
            endcase
        end
    end

    dpc_window #(.DW(DW), .MAX_W(MAX_W), .XW(XW)) u_window (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (in_valid),
        .in_fs  (in_fs),
        .in_ls  (in_ls),
        .in_pix (in_pix),
        .width  (width),
        .win    (win),
        .ctr_fs (ctr_fs),
        .ctr_ls (ctr_ls),
        .nxt_fs (nxt_fs),
        .nxt_ls (nxt_ls)
    );

    // Frame position of the pixel entering the window centre.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crow <= '0;
            ccol <= '0;
        end else if (in_valid) begin
            if (nxt_fs) begin
                crow <= '0;
                ccol <= '0;
            end else if (nxt_ls) begin
                crow <= crow + YW'(1);
                ccol <= '0;
            end else begin
                ccol <= ccol + XW'(1);
            end
        end
    end

    // Which window sides reach outside the frame.
    assign kk     = ctrl.mono ? 2'd1 : 2'd2;
    assign ok_up  = crow >= YW'(kk);
    assign ok_dn  = ({1'b0, crow} + (YW+1)'(kk)) < {1'b0, height};
    assign ok_lf  = ccol >= XW'(kk);
    assign ok_rt  = ({1'b0, ccol} + (XW+1)'(kk)) < {1'b0, width};
    assign border = !(ok_up && ok_dn && ok_lf && ok_rt);

    // Neighbour selection with mirrored taps at the frame edge.
    always_comb begin
        for (int d = 0; d < NUM_NB; d++) begin
            int         sy, sx;
            logic [2:0] yi, xi;
            sy = DIR_Y[d];
            sx = DIR_X[d];
            if ((sy < 0) && !ok_up) sy = 1;
            else if ((sy > 0) && !ok_dn) sy = -1;
            if ((sx < 0) && !ok_lf) sx = 1;
            else if ((sx > 0) && !ok_rt) sx = -1;
            yi = 3'(2 + sy * int'(kk));
            xi = 3'(2 + sx * int'(kk));
            nb[d] = win[yi][xi];
        end
    end

    dpc_estimate #(.DW(DW)) u_estimate (
        .clk   (clk),
        .rst_n (rst_n),
        .nb    (nb),
        .nmin  (nmin),
        .nmax  (nmax),
        .nmed  (nmed),
        .nmean (nmean)
    );

    // Outlier test against neighbour extremes plus threshold.
    assign ctr_pix = win[2][2];
    assign hot     = {1'b0, ctr_pix} > ({1'b0, nmax} + {1'b0, thr});
    assign cold    = ({1'b0, ctr_pix} + {1'b0, thr}) < {1'b0, nmin};
    assign fix     = !ctrl.bypass && !(ctrl.skip_edge && border) && (hot || cold);
    assign est     = ctrl.use_mean ? nmean : nmed;

    // Output register: one result per input beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_fs    <= 1'b0;
            out_ls    <= 1'b0;
            out_pix   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_fs  <= ctr_fs;
                out_ls  <= ctr_ls;
                out_pix <= fix ? est : ctr_pix;
            end
        end
    end

    p_bypass_unchanged_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ctrl.bypass) |=> (out_pix == $past(win[2][2])));
    p_hot_lowered_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && fix && hot) |=> (out_pix < $past(ctr_pix)));
    p_cold_raised_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && fix && cold) |=> (out_pix > $past(ctr_pix)));
    p_fix_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && fix) |=> ((out_pix >= $past(nmin)) && (out_pix <= $past(nmax))));
    p_skip_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ctrl.skip_edge && border) |=> (out_pix == $past(win[2][2])));

endmodule

// File: tb/bayer_dpc_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues expected pixels, the monitor compares.
module bayer_dpc_bench;
    localparam int DW = 8, MAX_W = 16, MAX_H = 16, CW = 16;
    localparam int W = 8, H = 6, D = 2 * W + 3;

    logic          clk = 1'b0, rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_addr = '0;
    logic [CW-1:0] cfg_wdata = '0;
    logic          in_valid = 1'b0, in_fs = 1'b0, in_ls = 1'b0;
    logic [DW-1:0] in_pix = '0;
    logic          out_valid, out_fs, out_ls;
    logic [DW-1:0] out_pix;

    typedef struct {
        int    pix;
        bit    fs;
        bit    ls;
        bit    skip;
        string tag;
    } exp_t;

    exp_t  q[$];
    int    n_cmp = 0, n_bad = 0, cyc = 0;
    bit    done = 0;
    int    img [H][W];
    int    c_bypass, c_mono, c_mean, c_skip, c_thr;
    string deftag;

    bayer_dpc #(.DW(DW), .MAX_W(MAX_W), .MAX_H(MAX_H), .CW(CW)) u_bayer_dpc (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_fs(in_fs),
        .in_ls(in_ls), .in_pix(in_pix), .out_valid(out_valid),
        .out_fs(out_fs), .out_ls(out_ls), .out_pix(out_pix)
    );

    always #2.5 clk = ~clk;

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            done = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: act running exp finished");
            summary();
        end
    end

    // Monitor: pop one expected entry per output beat.
    always @(negedge clk) begin
        if (rst_n && out_valid && q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            if (!e.skip) begin
                n_cmp++;
                if (int'(out_pix) != e.pix) begin
                    n_bad++;
                    $display("FAIL %s pix: act %0d exp %0d", e.tag, out_pix, e.pix);
                end
                n_cmp++;
                if (out_fs != e.fs || out_ls != e.ls) begin
                    n_bad++;
                    $display("FAIL R1 sync: act %0b%0b exp %0b%0b", out_fs, out_ls, e.fs, e.ls);
                end
            end
        end
    end

    // Reference model of one output pixel.
    function automatic void ref_px(input int y, input int x, output int v, output string tag);
        int k, nb[8], n, ty, tx, c, sum, t, mn, mx, est;
        bit brd, hot, cold;
        k = c_mono ? 1 : 2;
        c = img[y][x];
        n = 0;
        sum = 0;
        for (int sy = -1; sy <= 1; sy++) begin
            for (int sx = -1; sx <= 1; sx++) begin
                if (sy != 0 || sx != 0) begin
                    ty = y + sy * k;
                    if (ty < 0 || ty > H - 1) ty = y - sy * k;
                    tx = x + sx * k;
                    if (tx < 0 || tx > W - 1) tx = x - sx * k;
                    nb[n] = img[ty][tx];
                    sum += nb[n];
                    n++;
                end
            end
        end
        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 7 - i; j++) begin
                if (nb[j] > nb[j+1]) begin
                    t = nb[j]; nb[j] = nb[j+1]; nb[j+1] = t;
                end
            end
        end
        mn = nb[0];
        mx = nb[7];
        est = c_mean ? sum / 8 : (nb[3] + nb[4]) / 2;
        brd = (y < k) || (y > H - 1 - k) || (x < k) || (x > W - 1 - k);
        hot = c > mx + c_thr;
        cold = c + c_thr < mn;
        v = c;
        tag = deftag;
        if (c_bypass) begin
            tag = "R2";
        end else if (c_skip && brd) begin
            tag = "R10";
        end else if (hot || cold) begin
            v = est;
            tag = {hot ? "R3 " : "R4 ", c_mean ? "R6" : "R5", brd ? " R9" : ""};
        end else if (brd) begin
            tag = {deftag, " R9"};
        end
    endfunction

    task automatic wr(input logic [1:0] a, input int d);
        cfg_we = 1'b1;
        cfg_addr = a;
        cfg_wdata = CW'(d);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic reset_dut();
        q.delete();
        rst_n = 1'b0;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Reset, program registers, queue the window-fill placeholders.
    task automatic setup(input int byp, input int mono, input int mean,
                         input int skip, input int thr, input bit wr_ctrl,
                         input string tag);
        exp_t e;
        reset_dut();
        if (wr_ctrl) begin
            wr(2'd0, (skip << 3) | (mean << 2) | (mono << 1) | byp);
            wr(2'd1, thr);
        end
        wr(2'd2, W);
        wr(2'd3, H);
        c_bypass = byp; c_mono = mono; c_mean = mean; c_skip = skip; c_thr = thr;
        deftag = tag;
        e.pix = 0; e.fs = 0; e.ls = 0; e.skip = 1; e.tag = "";
        for (int i = 0; i < D; i++) q.push_back(e);
    endtask

    task automatic beat(input int p, input bit fs, input bit ls);
        in_valid = 1'b1;
        in_fs = fs;
        in_ls = ls;
        in_pix = DW'(p);
        @(negedge clk);
        in_valid = 1'b0;
        in_fs = 1'b0;
        in_ls = 1'b0;
    endtask

    // Drive one frame with an idle cycle per line, then flush.
    task automatic send_frame();
        exp_t e;
        for (int y = 0; y < H; y++) begin
            for (int x = 0; x < W; x++) begin
                ref_px(y, x, e.pix, e.tag);
                e.fs = (y == 0 && x == 0);
                e.ls = (x == 0);
                e.skip = 0;
                q.push_back(e);
                beat(img[y][x], e.fs, e.ls);
            end
            @(negedge clk);
        end
        for (int i = 0; i < D; i++) beat(0, i == 0, i % W == 0);
        repeat (3) @(negedge clk);
        n_cmp++;
        if (q.size() != 0) begin
            n_bad++;
            $display("FAIL R1 drain: act %0d left exp 0", q.size());
        end
    endtask

    task automatic gen_bayer();
        int base [2][2] = '{'{40, 120}, '{120, 200}};
        for (int y = 0; y < H; y++)
            for (int x = 0; x < W; x++)
                img[y][x] = base[y % 2][x % 2] + ((x * 3 + y * 5) % 7);
        img[2][4] = 250; img[3][3] = 150; img[0][0] = 255; img[5][7] = 0;
    endtask

    task automatic gen_flat();
        for (int y = 0; y < H; y++)
            for (int x = 0; x < W; x++)
                img[y][x] = 100;
        img[2][4] = 120; img[3][6] = 121; img[1][1] = 79; img[4][3] = 80;
    endtask

    task automatic gen_mono();
        for (int y = 0; y < H; y++)
            for (int x = 0; x < W; x++)
                img[y][x] = 100 + ((x + y) % 5);
        img[3][3] = 250; img[2][5] = 0; img[0][4] = 255;
    endtask

    initial begin
        reset_dut();
        n_cmp++;
        if (out_valid !== 1'b0 || out_pix !== '0) begin
            n_bad++;
            $display("FAIL R11 reset: act %0b/%0d exp 0/0", out_valid, out_pix);
        end
        // R7: colour mode, median, mirrored edges.
        setup(0, 0, 0, 0, 20, 1, "R7"); gen_bayer(); send_frame();
        // R6: mean estimator.
        setup(0, 0, 1, 0, 20, 1, "R7"); gen_bayer(); send_frame();
        // R10: skip edge pixels.
        setup(0, 0, 0, 1, 20, 1, "R7"); gen_bayer(); send_frame();
        // R8: monochrome neighbourhood on a flat image and on a Bayer image.
        setup(0, 1, 0, 0, 20, 1, "R8"); gen_mono(); send_frame();
        setup(0, 1, 0, 0, 20, 1, "R8"); gen_bayer(); send_frame();
        // R2: bypass.
        setup(1, 0, 0, 0, 20, 1, "R2"); gen_bayer(); send_frame();
        // R3 and R4 threshold boundaries on a flat field.
        setup(0, 0, 0, 0, 20, 1, "R3 R4"); gen_flat(); send_frame();
        // R11: threshold register at its maximum suppresses all repair.
        setup(0, 0, 0, 0, 255, 1, "R11"); gen_bayer(); send_frame();
        // R11: reset defaults for control and threshold.
        setup(0, 0, 0, 0, 0, 0, "R11"); gen_bayer(); send_frame();
        done = 1;
        summary();
    end

endmodule